// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a translation that missed in the TLB. It takes the full 32-bit virtual address and the base of the current first-level table. It then walks a two-level page table kept in memory. The address is treated as a 10-bit first-level index (bits 31:22), a 10-bit second-level index (bits 21:12) and a 12-bit page offset. Each table has 1024 entries of 4 bytes. The walker reads one entry per level through a memory read port that allows one request in flight. It ends either with the 20-bit physical frame number or with a fault.

The fault says which level was missing. A first-level slot that is unused has its valid bit clear. That means its second-level table is not resident, and the walk stops after a single read. A second-level entry with its present bit clear means the page itself is absent. The faulting virtual address goes out with the fault, ready for the handler.

Top module: `ptw_walker`

## Requirements
- R1: After reset the walker is idle: `busy`, `done`, `fault` and `mem_req_valid` are all low.
- R2: The first read goes to address `pt_base + 4 * va[31:22]`, using the `pt_base` value captured when the request was accepted.
- R3: If bit 0 of the first-level entry is 0, the walk ends with `fault` high and `fault_level` = 0, after exactly one memory read.
- R4: If bit 0 of the first-level entry is 1, the second read goes to `{l1_entry[31:12], 12'h000} + 4 * va[21:12]`.
- R5: If bit 0 of the second-level entry is 0, the walk ends with `fault` high and `fault_level` = 1, after exactly two memory reads.
- R6: If bit 0 of the second-level entry is 1, the walk ends with `done` high and `done_ppn` equal to bits 31:12 of that entry.
- R7: While `fault` is high, `fault_va` equals the virtual address of the request that faulted.
- R8: `done` and `fault` are never high together, and each stays high for exactly one cycle per walk.
- R9: A request is accepted only when `req_valid` is high while the walker is idle. A request presented while `busy` is high has no effect on the walk in progress.
- R10: There is at most one memory read outstanding. A request stays asserted with a stable address until `mem_req_ready` accepts it, and no new request is raised before the response returns.
- R11: A change of `pt_base` after a request has been accepted has no effect on that walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request from a TLB miss |
| req_va | input | 32 | Virtual address to translate |
| pt_base | input | 32 | Physical base of the first-level table |
| busy | output | 1 | High while a walk is in progress |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_addr | output | 32 | Byte address of the entry to read |
| mem_req_ready | input | 1 | Memory accepts the request this cycle |
| mem_rsp_valid | input | 1 | Read data is returned this cycle |
| mem_rsp_data | input | 32 | Entry read from memory |
| done | output | 1 | One-cycle pulse: translation found |
| done_ppn | output | 20 | Physical frame number, valid with `done` |
| fault | output | 1 | One-cycle pulse: page fault |
| fault_level | output | 1 | 0 = second-level table missing, 1 = page missing |
| fault_va | output | 32 | Virtual address of the faulting walk |

## Verification
Two functions can meet in the same cycle: the completion pulse (`done` or `fault`) and the arrival of a new request. That new request must be ignored while the walker is still finishing. The bench provokes this in two ways. First, it keeps `req_valid` high with a different address and a different table base during a whole walk, up to and including the pulse cycle. Second, it chains a held request straight after a completion. For each case it checks that the first walk's read addresses and result come only from the first request. It also checks that the held request starts a fresh walk only once the walker has gone idle.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    localparam int VA_W      = 32;
    localparam int PA_W      = 32;
    localparam int IDX_W     = 10;
    localparam int OFF_W     = VA_W - 2 * IDX_W;
    localparam int PTE_W     = 32;
    localparam int PTE_BYTES = PTE_W / 8;
    localparam int PTE_SHIFT = $clog2(PTE_BYTES);
    localparam int PPN_W     = PA_W - OFF_W;
    localparam int ATTR_W    = PTE_W - PPN_W - 1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD1,
        ST_WT1,
        ST_RD2,
        ST_WT2,
        ST_DONE,
        ST_FAULT
    } walk_state_e;

    typedef enum logic {
        FLT_NO_TABLE = 1'b0,
        FLT_NO_PAGE  = 1'b1
    } fault_lvl_e;

    typedef struct packed {
        logic [PPN_W-1:0]  ppn;
        logic [ATTR_W-1:0] attrs;
        logic              valid;
    } pte_t;

    function automatic logic [IDX_W-1:0] top_index(input logic [VA_W-1:0] va);
        return va[VA_W-1 -: IDX_W];
    endfunction

    function automatic logic [IDX_W-1:0] mid_index(input logic [VA_W-1:0] va);
        return va[OFF_W +: IDX_W];
    endfunction

    function automatic logic [PA_W-1:0] slot_addr(input logic [PA_W-1:0] base,
                                                  input logic [IDX_W-1:0] idx);
        logic [PA_W-1:0] scaled;
        scaled = {{(PA_W-IDX_W){1'b0}}, idx} << PTE_SHIFT;
        return base + scaled;
    endfunction

    function automatic logic [PA_W-1:0] frame_base(input logic [PPN_W-1:0] ppn);
        return {ppn, {OFF_W{1'b0}}};
    endfunction

endpackage

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
    import ptw_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic        mem_req_ready,
    input  logic        mem_rsp_valid,
    input  logic        entry_valid,
    output walk_state_e state,
    output logic        accept,
    output logic        take_l1,
    output logic        take_l2,
    output logic        busy,
    output logic        rd_valid,
    output logic        done,
    output logic        fault,
    output fault_lvl_e  fault_level
);

    walk_state_e state_q, state_d;
    fault_lvl_e  lvl_q, lvl_d;

    always_comb begin
        state_d = state_q;
        lvl_d   = lvl_q;
        accept  = 1'b0;
        take_l1 = 1'b0;
        take_l2 = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    accept  = 1'b1;
                    state_d = ST_RD1;
                end
            end
            ST_RD1: if (mem_req_ready) state_d = ST_WT1;
            ST_WT1: begin
                if (mem_rsp_valid) begin
                    if (entry_valid) begin
                        take_l1 = 1'b1;
                        state_d = ST_RD2;
                    end else begin
                        lvl_d   = FLT_NO_TABLE;
                        state_d = ST_FAULT;
                    end
                end
            end
            ST_RD2: if (mem_req_ready) state_d = ST_WT2;
            ST_WT2: begin
                if (mem_rsp_valid) begin
                    if (entry_valid) begin
                        take_l2 = 1'b1;
                        state_d = ST_DONE;
                    end else begin
                        lvl_d   = FLT_NO_PAGE;
                        state_d = ST_FAULT;
                    end
                end
            end
            ST_DONE:  state_d = ST_IDLE;
            ST_FAULT: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            lvl_q   <= FLT_NO_TABLE;
        end else begin
            state_q <= state_d;
            lvl_q   <= lvl_d;
        end
    end

    assign state       = state_q;
    assign busy        = (state_q != ST_IDLE);
    assign rd_valid    = (state_q == ST_RD1) || (state_q == ST_RD2);
    assign done        = (state_q == ST_DONE);
    assign fault       = (state_q == ST_FAULT);
    assign fault_level = lvl_q;

    // R3
    l1_absent_faults_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WT1 && mem_rsp_valid && !entry_valid)
        |=> (fault && fault_level == FLT_NO_TABLE));

    // R5
    l2_absent_faults_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WT2 && mem_rsp_valid && !entry_valid)
        |=> (fault && fault_level == FLT_NO_PAGE));

    // R8
    done_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done && !fault);

    // R8
    fault_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        fault |=> !fault && !done);

    // R10
    one_outstanding_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && mem_req_ready) |=> !rd_valid);

    // R10
    req_held_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && !mem_req_ready) |=> rd_valid);

endmodule

// File: rtl/ptw_regs.sv
module ptw_regs
    import ptw_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             accept,
    input  logic             take_l1,
    input  logic             take_l2,
    input  logic [VA_W-1:0]  req_va,
    input  logic [PA_W-1:0]  pt_base,
    input  logic [PTE_W-1:0] rsp_data,
    output logic [VA_W-1:0]  va_q,
    output logic [PA_W-1:0]  base_q,
    output logic [PPN_W-1:0] l2_tbl_q,
    output logic [PPN_W-1:0] ppn_q,
    output logic             entry_valid
);

    pte_t entry;

    assign entry       = pte_t'(rsp_data);
    assign entry_valid = entry.valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            va_q     <= '0;
            base_q   <= '0;
            l2_tbl_q <= '0;
            ppn_q    <= '0;
        end else begin
            if (accept) begin
                va_q   <= req_va;
                base_q <= pt_base;
            end
            if (take_l1) l2_tbl_q <= entry.ppn;
            if (take_l2) ppn_q    <= entry.ppn;
        end
    end

    // R9
    va_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        !accept |=> $stable(va_q));

    // R11
    base_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        !accept |=> $stable(base_q));

endmodule

// File: rtl/ptw_addr.sv
module ptw_addr
    import ptw_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  walk_state_e      state,
    input  logic             rd_valid,
    input  logic             mem_req_ready,
    input  logic [VA_W-1:0]  va_q,
    input  logic [PA_W-1:0]  base_q,
    input  logic [PPN_W-1:0] l2_tbl_q,
    output logic [PA_W-1:0]  mem_addr
);

    logic [PA_W-1:0] l1_slot;
    logic [PA_W-1:0] l2_slot;

    assign l1_slot  = slot_addr(base_q, top_index(va_q));
    assign l2_slot  = slot_addr(frame_base(l2_tbl_q), mid_index(va_q));
    assign mem_addr = (state == ST_RD2) ? l2_slot : l1_slot;

    // R10
    addr_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && !mem_req_ready) |=> $stable(mem_addr));

endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic [31:0] req_va,
    input  logic [31:0] pt_base,
    output logic        busy,
    output logic        mem_req_valid,
    output logic [31:0] mem_req_addr,
    input  logic        mem_req_ready,
    input  logic        mem_rsp_valid,
    input  logic [31:0] mem_rsp_data,
    output logic        done,
    output logic [19:0] done_ppn,
    output logic        fault,
    output logic        fault_level,
    output logic [31:0] fault_va
);

    walk_state_e      state;
    fault_lvl_e       lvl;
    logic             accept;
    logic             take_l1;
    logic             take_l2;
    logic             entry_valid;
    logic [VA_W-1:0]  va_q;
    logic [PA_W-1:0]  base_q;
    logic [PPN_W-1:0] l2_tbl_q;
    logic [PPN_W-1:0] ppn_q;

    ptw_ctrl u_ctrl (
        .clk           (clk),
        .rst           (rst),
        .req_valid     (req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_rsp_valid (mem_rsp_valid),
        .entry_valid   (entry_valid),
        .state         (state),
        .accept        (accept),
        .take_l1       (take_l1),
        .take_l2       (take_l2),
        .busy          (busy),
        .rd_valid      (mem_req_valid),
        .done          (done),
        .fault         (fault),
        .fault_level   (lvl)
    );

    ptw_regs u_regs (
        .clk         (clk),
        .rst         (rst),
        .accept      (accept),
        .take_l1     (take_l1),
        .take_l2     (take_l2),
        .req_va      (req_va),
        .pt_base     (pt_base),
        .rsp_data    (mem_rsp_data),
        .va_q        (va_q),
        .base_q      (base_q),
        .l2_tbl_q    (l2_tbl_q),
        .ppn_q       (ppn_q),
        .entry_valid (entry_valid)
    );

    ptw_addr u_addr (
        .clk           (clk),
        .rst           (rst),
        .state         (state),
        .rd_valid      (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .va_q          (va_q),
        .base_q        (base_q),
        .l2_tbl_q      (l2_tbl_q),
        .mem_addr      (mem_req_addr)
    );

    assign done_ppn    = ppn_q;
    assign fault_level = lvl;
    assign fault_va    = va_q;

    // R8
    done_fault_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(done && fault));

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mem_req_valid && !done && !fault));

endmodule

// File: tb/ptw_walker_tb.sv
module ptw_walker_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic [31:0] req_va;
    logic [31:0] pt_base;
    logic        busy;
    logic        mem_req_valid;
    logic [31:0] mem_req_addr;
    logic        mem_req_ready;
    logic        mem_rsp_valid;
    logic [31:0] mem_rsp_data;
    logic        done;
    logic [19:0] done_ppn;
    logic        fault;
    logic        fault_level;
    logic [31:0] fault_va;

    int total = 0;
    int bad   = 0;

    logic [31:0] rec [0:3];
    int rd_cnt    = 0;
    int ov_l1     = 0;
    int ov_l2     = 0;
    int proto_err = 0;

    always #4 clk = ~clk;

    ptw_walker u_dut (
        .clk           (clk),
        .rst           (rst),
        .req_valid     (req_valid),
        .req_va        (req_va),
        .pt_base       (pt_base),
        .busy          (busy),
        .mem_req_valid (mem_req_valid),
        .mem_req_addr  (mem_req_addr),
        .mem_req_ready (mem_req_ready),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .done          (done),
        .done_ppn      (done_ppn),
        .fault         (fault),
        .fault_level   (fault_level),
        .fault_va      (fault_va)
    );

    function automatic logic [31:0] mem_raw(input logic [31:0] a);
        logic [31:0] h;
        h = a ^ (a >> 13);
        h = h * 32'h2c1b3c6d;
        h = h ^ (h >> 15);
        return h;
    endfunction

    function automatic logic [31:0] apply_ov(input logic [31:0] w, input int ov);
        if (ov == 1) return w | 32'h1;
        if (ov == 2) return w & ~32'h1;
        return w;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // memory model: one read at a time, random stall and latency
    initial begin : responder
        int st;
        int lat;
        bit waited;
        logic [31:0] prev_addr;
        logic [31:0] data_q;
        st = 0; lat = 0; waited = 0; prev_addr = '0; data_q = '0;
        mem_req_ready = 1'b0;
        mem_rsp_valid = 1'b0;
        mem_rsp_data  = '0;
        forever begin
            @(negedge clk);
            mem_req_ready = 1'b0;
            mem_rsp_valid = 1'b0;
            if (rst) begin
                st = 0; waited = 0;
            end else if (st == 0) begin
                if (mem_req_valid) begin
                    if (waited && mem_req_addr != prev_addr) proto_err++;
                    if ($urandom % 3 != 0) begin
                        mem_req_ready = 1'b1;
                        if (rd_cnt < 4) rec[rd_cnt] = mem_req_addr;
                        data_q = apply_ov(mem_raw(mem_req_addr), (rd_cnt == 0) ? ov_l1 : ov_l2);
                        rd_cnt++;
                        lat = $urandom % 4;
                        st = 1;
                        waited = 0;
                    end else begin
                        waited = 1;
                        prev_addr = mem_req_addr;
                    end
                end
            end else begin
                if (mem_req_valid) proto_err++;
                if (lat == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = data_q;
                    st = 0;
                end else begin
                    lat--;
                end
            end
        end
    end

    task automatic start(input logic [31:0] va, input logic [31:0] base,
                         input bit hold, input logic [31:0] va2, input logic [31:0] base2);
        @(negedge clk);
        req_valid = 1'b1;
        req_va    = va;
        pt_base   = base;
        rd_cnt    = 0;
        @(negedge clk);
        if (hold) begin
            req_va  = va2;
            pt_base = base2;
        end else begin
            req_valid = 1'b0;
        end
    endtask

    task automatic finish(input logic [31:0] va, input logic [31:0] base, input bit mess);
        logic [31:0] l1a, l1e, l2a, l2e;
        int cyc;
        bit seen;
        seen = 0;
        for (cyc = 0; cyc < 200; cyc++) begin
            if (done || fault) begin
                if (mess) req_valid = 1'b0;
                seen = 1;
                break;
            end
            if (mess) begin
                req_valid = 1'b1;
                req_va    = ~va;
                pt_base   = ~base;
            end
            @(negedge clk);
        end
        chk(seen, "R8 walk completes", {31'b0, seen}, 32'h1);
        if (!seen) return;
        l1a = base + {20'b0, va[31:22], 2'b00};
        l1e = apply_ov(mem_raw(l1a), ov_l1);
        chk(rec[0] == l1a, "R2 first read address", rec[0], l1a);
        chk(!(done && fault), "R8 done/fault exclusive", {30'b0, done, fault}, 32'h0);
        if (!l1e[0]) begin
            chk(fault && fault_level == 1'b0, "R3 missing table fault",
                {30'b0, fault, fault_level}, 32'h2);
            chk(rd_cnt == 1, "R3 single read", rd_cnt, 32'd1);
            chk(fault_va == va, "R7 fault address", fault_va, va);
        end else begin
            l2a = {l1e[31:12], 12'h000} + {20'b0, va[21:12], 2'b00};
            l2e = apply_ov(mem_raw(l2a), ov_l2);
            chk(rec[1] == l2a, "R4 second read address", rec[1], l2a);
            chk(rd_cnt == 2, "R4 two reads", rd_cnt, 32'd2);
            if (!l2e[0]) begin
                chk(fault && fault_level == 1'b1, "R5 missing page fault",
                    {30'b0, fault, fault_level}, 32'h3);
                chk(fault_va == va, "R7 fault address", fault_va, va);
            end else begin
                chk(done && !fault, "R6 done raised", {30'b0, done, fault}, 32'h2);
                chk(done_ppn == l2e[31:12], "R6 frame number",
                    {12'b0, done_ppn}, {12'b0, l2e[31:12]});
            end
        end
        @(negedge clk);
        rd_cnt = 0;
        chk(!done && !fault && !busy, "R8 one-cycle pulse",
            {29'b0, done, fault, busy}, 32'h0);
    endtask

    task automatic walk(input logic [31:0] va, input logic [31:0] base,
                        input int o1, input int o2, input bit mess);
        ov_l1 = o1;
        ov_l2 = o2;
        start(va, base, 1'b0, '0, '0);
        finish(va, base, mess);
    endtask

    initial begin : watchdog
        #(8 * 150000);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
    end

    initial begin : main
        void'($urandom(32'd4242));
        rst       = 1'b1;
        req_valid = 1'b0;
        req_va    = '0;
        pt_base   = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        chk(!busy && !done && !fault && !mem_req_valid, "R1 reset idle",
            {28'b0, busy, done, fault, mem_req_valid}, 32'h0);

        // directed corners
        walk(32'h0000_0000, 32'h0001_0000, 2, 0, 1'b0); // R3
        walk(32'hFFFF_FFFF, 32'hFFFF_F000, 1, 2, 1'b0); // R5, top indices
        walk(32'h1234_5678, 32'h0040_0000, 1, 1, 1'b0); // R6
        walk(32'h003F_F000, 32'h8000_0000, 1, 1, 1'b0); // R4 index 1023 at level 2
        // R9 R11: requests and a base change during a busy walk
        walk(32'hCAFE_1234, 32'h0020_0000, 1, 1, 1'b1);
        walk(32'h8765_4321, 32'h0030_0000, 2, 0, 1'b1);
        walk(32'h4444_4000, 32'h0050_0000, 1, 2, 1'b1);

        // R9: request held through completion starts a fresh walk afterwards
        ov_l1 = 1; ov_l2 = 1;
        start(32'h0ABC_D000, 32'h0060_0000, 1'b1, 32'h5555_A000, 32'h0070_0000);
        finish(32'h0ABC_D000, 32'h0060_0000, 1'b0);
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy, "R9 held request accepted after idle", {31'b0, busy}, 32'h1);
        finish(32'h5555_A000, 32'h0070_0000, 1'b0);

        // random walks
        for (int i = 0; i < 60; i++) begin
            walk($urandom, {$urandom, 2'b00} & 32'hFFFF_F000, 0, 0, (i % 5) == 0);
        end

        // R10
        chk(proto_err == 0, "R10 single outstanding, stable address", proto_err, 32'h0);
        summary();
    end

endmodule